// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier with Refresh Row Counter

This block sits on the device side of an asynchronous-strobe DRAM interface. A fast sampling clock watches the active-low row strobe, column strobe, write strobe and output-enable strobe. The block works out what kind of memory cycle the controller is running from the order in which these strobes change. It does not read a command code. The decisions rest on three things: whether the column strobe is already low when the row strobe falls, whether the write strobe is low at that point, and whether the write strobe falls before or after a column access begins.

From that classification it produces the control that a behavioural array needs:
- a row latch pulse and the row to open or refresh, taken either from the address pins or from an internal refresh row counter;
- a column latch pulse and the latched column;
- a write pulse;
- a data-output enable, whose low value means the data pins float;
- a sticky test-mode flag.

A decoded cycle-type code appears for one sample after each deciding edge, so the controller's strobe sequence can be checked against it. The internal counter supplies the row for column-before-row refreshes. It advances by one on each such refresh and wraps at the top of its range.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While reset is high, and on the first sample after it, every output is 0. The internal counter is cleared, so the first counter-driven refresh after reset uses row 0.
- R2: A row strobe fall with the column strobe high is an activate. One sample later `kind`=1, `row_stb` pulses and `row_sel` holds the address present at the fall.
- R3: Inside an open row, a column strobe fall with the write strobe high is a read. One sample later `kind`=2, `col_stb` pulses and `col_sel` holds the column address. From that sample on, `dq_oe` is 1 exactly when the previous sample had the column strobe low and output enable low, and the access is still a read.
- R4: Inside an open row, a column strobe fall with the write strobe already low is an early write. It gives `kind`=3, `col_stb` and `wr_stb`, and `dq_oe` stays 0 for that access.
- R5: During a read access with the column strobe low, a write strobe fall is a read-modify-write. One sample later `kind`=4 and `wr_stb` pulses, and from that sample on `dq_oe` is 0.
- R6: A row strobe rise that ends an activated row in which no column strobe fell is a row-only refresh. It gives `kind`=5, `refresh_stb`, `row_sel` equal to the activated row, and `dq_oe`=0.
- R7: A row strobe fall with the column strobe low, the write strobe high and no read held over is a counter refresh. It gives `kind`=6 and `refresh_stb`, and `row_sel` equals the counter value. The counter then increments modulo 1024 (row 1023 is followed by row 0).
- R8: A row strobe fall with both the column strobe and the write strobe low is test-mode entry. It gives `kind`=8 and sets `test_mode`. It produces no `refresh_stb` and leaves the counter unchanged.
- R9: A read whose column strobe stays low while the row strobe rises and falls again (write strobe high) is a hidden refresh. It gives `kind`=7 and `refresh_stb`, `row_sel` takes the counter value and the counter advances. `dq_oe` remains 1 throughout.
- R10: `test_mode` stays set through activates, reads, writes and hidden refreshes. A row-only refresh (`kind`=5) or a counter refresh (`kind`=6) clears it from the sample after the deciding edge.
- R11: A column strobe fall while the row strobe is high has no effect. It produces no `kind`, no `col_stb` and no `wr_stb`.
- R12: `kind_valid` is 1 for exactly the sample after a deciding edge. In every other sample `kind_valid` is 0 and `kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| row_stb | output | 1 | Row latch pulse for an activate |
| row_sel | output | 10 | Row being opened or refreshed |
| col_stb | output | 1 | Column latch pulse |
| col_sel | output | 10 | Latched column address |
| wr_stb | output | 1 | Write pulse to the array |
| refresh_stb | output | 1 | Refresh pulse for `row_sel` |
| dq_oe | output | 1 | Drive data pins when 1, float them when 0 |
| test_mode | output | 1 | Test mode active |
| kind | output | 4 | Decoded cycle type (0 = none) |
| kind_valid | output | 1 | `kind` carries a decision this sample |

## Verification
Each of the following faults shows up within one sample of the strobe edge that would have used the bad state:
- A stale open-row or column-seen flag misclassifies the next row strobe rise, showing a missing or extra row-only refresh.
- A lost read-hold flag turns a hidden refresh into a plain counter refresh, and `dq_oe` drops while the column strobe is still low.
- A wrong counter step or a missing wrap shows up as a wrong `row_sel` on the next counter refresh, so the bench walks the counter through all 1024 rows and past the wrap.
- A test-mode flag that is never set or never cleared shows on `test_mode` at once.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    localparam int ADDR_W_DEF = 10;

    typedef enum logic [3:0] {
        CK_NONE       = 4'd0,
        CK_ACTIVATE   = 4'd1,
        CK_READ       = 4'd2,
        CK_EARLY_WR   = 4'd3,
        CK_RMW        = 4'd4,
        CK_ROW_REF    = 4'd5,
        CK_CBR_REF    = 4'd6,
        CK_HIDDEN_REF = 4'd7,
        CK_TEST_ENTRY = 4'd8
    } cyc_kind_e;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic we_fall;
    } strobe_edges_t;

    function automatic logic is_refresh(input cyc_kind_e k);
        return (k == CK_ROW_REF) || (k == CK_CBR_REF) || (k == CK_HIDDEN_REF);
    endfunction

endpackage

// File: rtl/dsd_strobe_edges.sv
module dsd_strobe_edges
    import dsd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    output strobe_edges_t edges
);

    logic ras_q, cas_q, we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    always_comb begin
        edges.ras_fall = ras_q & ~ras_n;
        edges.ras_rise = ~ras_q & ras_n;
        edges.cas_fall = cas_q & ~cas_n;
        edges.we_fall  = we_q & ~we_n;
    end

endmodule

// File: rtl/dsd_refresh_counter.sv
module dsd_refresh_counter #(
    parameter int WIDTH = dsd_pkg::ADDR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (adv) count <= count + STEP;
    end

endmodule

// File: rtl/dsd_cycle_classifier.sv
module dsd_cycle_classifier
    import dsd_pkg::*;
#(
    parameter int AW = ADDR_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_edges_t edges,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ctr,
    output logic          adv,
    output logic          row_stb,
    output logic [AW-1:0] row_sel,
    output logic          col_stb,
    output logic [AW-1:0] col_sel,
    output logic          wr_stb,
    output logic          refresh_stb,
    output logic          dq_oe,
    output logic          test_mode,
    output cyc_kind_e     kind,
    output logic          kind_valid
);

    logic      row_open, cas_seen, read_act;
    logic      row_open_n, cas_seen_n, read_act_n, test_n;
    logic      row_load, col_load, wr_n, ref_n;
    cyc_kind_e kind_n;

    always_comb begin
        kind_n     = CK_NONE;
        row_open_n = row_open;
        cas_seen_n = cas_seen;
        read_act_n = read_act;
        test_n     = test_mode;
        row_load   = 1'b0;
        col_load   = 1'b0;
        wr_n       = 1'b0;
        ref_n      = 1'b0;
        adv        = 1'b0;
        if (edges.ras_fall) begin
            if (!cas_n) begin
                row_open_n = 1'b0;
                if (!we_n) begin
                    kind_n = CK_TEST_ENTRY;
                    test_n = 1'b1;
                end else if (read_act) begin
                    kind_n = CK_HIDDEN_REF;
                    ref_n  = 1'b1;
                    adv    = 1'b1;
                end else begin
                    kind_n = CK_CBR_REF;
                    ref_n  = 1'b1;
                    adv    = 1'b1;
                    test_n = 1'b0;
                end
            end else begin
                kind_n     = CK_ACTIVATE;
                row_open_n = 1'b1;
                cas_seen_n = 1'b0;
                row_load   = 1'b1;
            end
        end else if (edges.ras_rise) begin
            if (row_open && !cas_seen) begin
                kind_n = CK_ROW_REF;
                ref_n  = 1'b1;
                test_n = 1'b0;
            end
            row_open_n = 1'b0;
        end else if (row_open && edges.cas_fall) begin
            cas_seen_n = 1'b1;
            col_load   = 1'b1;
            if (!we_n) begin
                kind_n = CK_EARLY_WR;
                wr_n   = 1'b1;
            end else begin
                kind_n     = CK_READ;
                read_act_n = 1'b1;
            end
        end else if (row_open && read_act && edges.we_fall && !cas_n) begin
            kind_n     = CK_RMW;
            wr_n       = 1'b1;
            read_act_n = 1'b0;
        end
        if (cas_n) read_act_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open    <= 1'b0;
            cas_seen    <= 1'b0;
            read_act    <= 1'b0;
            test_mode   <= 1'b0;
            kind        <= CK_NONE;
            kind_valid  <= 1'b0;
            row_stb     <= 1'b0;
            col_stb     <= 1'b0;
            wr_stb      <= 1'b0;
            refresh_stb <= 1'b0;
            dq_oe       <= 1'b0;
            row_sel     <= '0;
            col_sel     <= '0;
        end else begin
            row_open    <= row_open_n;
            cas_seen    <= cas_seen_n;
            read_act    <= read_act_n;
            test_mode   <= test_n;
            kind        <= kind_n;
            kind_valid  <= (kind_n != CK_NONE);
            row_stb     <= row_load;
            col_stb     <= col_load;
            wr_stb      <= wr_n;
            refresh_stb <= ref_n;
            dq_oe       <= read_act_n & ~cas_n & ~oe_n;
            if (row_load)   row_sel <= addr;
            else if (adv)   row_sel <= ctr;
            if (col_load)   col_sel <= addr;
        end
    end

    // R3
    dq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(!cas_n && !oe_n));

    // R4
    wr_float_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !dq_oe);

    // R6
    refresh_kind_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_stb |-> (kind_valid && is_refresh(kind)));

    // R8
    test_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(test_mode) |-> (kind == CK_TEST_ENTRY));

    // R11
    col_needs_cas_chk: assert property (@(posedge clk) disable iff (rst)
        col_stb |-> $past(!cas_n));

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              row_stb,
    output logic [ADDR_W-1:0] row_sel,
    output logic              col_stb,
    output logic [ADDR_W-1:0] col_sel,
    output logic              wr_stb,
    output logic              refresh_stb,
    output logic              dq_oe,
    output logic              test_mode,
    output logic [3:0]        kind,
    output logic              kind_valid
);

    strobe_edges_t     edges;
    logic              adv;
    logic [ADDR_W-1:0] ctr;
    cyc_kind_e         kind_e;

    dsd_strobe_edges u_edges (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .edges (edges)
    );

    dsd_refresh_counter #(.WIDTH(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .count (ctr)
    );

    dsd_cycle_classifier #(.AW(ADDR_W)) u_cls (
        .clk         (clk),
        .rst         (rst),
        .edges       (edges),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .addr        (addr),
        .ctr         (ctr),
        .adv         (adv),
        .row_stb     (row_stb),
        .row_sel     (row_sel),
        .col_stb     (col_stb),
        .col_sel     (col_sel),
        .wr_stb      (wr_stb),
        .refresh_stb (refresh_stb),
        .dq_oe       (dq_oe),
        .test_mode   (test_mode),
        .kind        (kind_e),
        .kind_valid  (kind_valid)
    );

    assign kind = kind_e;

    // R2
    row_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        row_stb |-> !$past(ras_n));

endmodule

// File: tb/dram_strobe_decoder_test.sv
module dram_strobe_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [9:0] addr = '0;
    logic       row_stb, col_stb, wr_stb, refresh_stb, dq_oe, test_mode, kind_valid;
    logic [9:0] row_sel, col_sel;
    logic [3:0] kind;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dram_strobe_decoder uut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .row_stb(row_stb), .row_sel(row_sel), .col_stb(col_stb),
        .col_sel(col_sel), .wr_stb(wr_stb), .refresh_stb(refresh_stb), .dq_oe(dq_oe),
        .test_mode(test_mode), .kind(kind), .kind_valid(kind_valid)
    );

    // vector: [31]ras [30]cas [29]we [28]oe [27:18]addr [17:14]kind
    //         [13]dq_oe [12]refresh [11]wr [10]test_mode [9:0]row
    function automatic logic [31:0] v(input logic [3:0] s, input logic [9:0] a,
                                      input logic [3:0] k, input logic d, input logic r,
                                      input logic w, input logic t, input logic [9:0] row);
        return {s, a, k, d, r, w, t, row};
    endfunction

    localparam int NV = 32;
    localparam logic [31:0] VEC [0:NV-1] = '{
        v(4'b1111, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 0 idle R12
        v(4'b0111, 10'h155, 4'd1, 0, 0, 0, 0, 10'h155), // 1 activate R2
        v(4'b0010, 10'h00A, 4'd2, 1, 0, 0, 0, 10'h000), // 2 read R3
        v(4'b0010, 10'h000, 4'd0, 1, 0, 0, 0, 10'h000), // 3 hold R3
        v(4'b0011, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 4 OE high R3
        v(4'b0010, 10'h000, 4'd0, 1, 0, 0, 0, 10'h000), // 5 OE low R3
        v(4'b0110, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 6 CAS high R3
        v(4'b0000, 10'h00B, 4'd3, 0, 0, 1, 0, 10'h000), // 7 early write R4
        v(4'b0111, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 8
        v(4'b1111, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 9 no refresh R6
        v(4'b0111, 10'h2AA, 4'd1, 0, 0, 0, 0, 10'h2AA), // 10 activate R2
        v(4'b1111, 10'h000, 4'd5, 0, 1, 0, 0, 10'h2AA), // 11 row-only refresh R6
        v(4'b1011, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 12 CAS with RAS high R11
        v(4'b0011, 10'h000, 4'd6, 0, 1, 0, 0, 10'h000), // 13 counter refresh row 0 R7
        v(4'b1011, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 14
        v(4'b1111, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 15
        v(4'b0111, 10'h00F, 4'd1, 0, 0, 0, 0, 10'h00F), // 16 activate R2
        v(4'b0010, 10'h030, 4'd2, 1, 0, 0, 0, 10'h000), // 17 read R3
        v(4'b0000, 10'h000, 4'd4, 0, 0, 1, 0, 10'h000), // 18 read-modify-write R5
        v(4'b0001, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 19 R5
        v(4'b1111, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 20
        v(4'b0111, 10'h100, 4'd1, 0, 0, 0, 0, 10'h100), // 21 activate R2
        v(4'b0010, 10'h000, 4'd2, 1, 0, 0, 0, 10'h000), // 22 read R3
        v(4'b1010, 10'h000, 4'd0, 1, 0, 0, 0, 10'h000), // 23 RAS high, data held R9
        v(4'b0010, 10'h000, 4'd7, 1, 1, 0, 0, 10'h001), // 24 hidden refresh row 1 R9
        v(4'b1010, 10'h000, 4'd0, 1, 0, 0, 0, 10'h000), // 25 R9
        v(4'b1110, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 26 R3
        v(4'b1011, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 27
        v(4'b1001, 10'h000, 4'd0, 0, 0, 0, 0, 10'h000), // 28
        v(4'b0001, 10'h000, 4'd8, 0, 0, 0, 1, 10'h000), // 29 test entry R8
        v(4'b1011, 10'h000, 4'd0, 0, 0, 0, 1, 10'h000), // 30 R10
        v(4'b1111, 10'h000, 4'd0, 0, 0, 0, 1, 10'h000)  // 31 R10
    };

    function automatic string tag_of(input logic [3:0] k);
        case (k)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R9";
            4'd8: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] s, input logic [9:0] a);
        @(negedge clk);
        {ras_n, cas_n, we_n, oe_n} = s;
        addr = a;
        @(posedge clk);
        #2;
    endtask

    task automatic expect_ref(input logic [3:0] k, input logic [9:0] row, input string req);
        check(kind == k && refresh_stb && row_sel == row, req,
              {18'd0, kind, row_sel}, {18'd0, k, row});
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<200000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check({row_stb, col_stb, wr_stb, refresh_stb, dq_oe, test_mode, kind_valid, kind} == '0,
              "R1 outputs in reset", {21'd0, row_stb, col_stb, wr_stb, refresh_stb, dq_oe,
              test_mode, kind_valid, kind}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check({row_stb, col_stb, wr_stb, refresh_stb, dq_oe, test_mode, kind_valid, kind} == '0 &&
              row_sel == '0 && col_sel == '0, "R1 after release", {22'd0, row_sel}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] e;
            logic [3:0]  ek;
            logic [10:0] obs, exp;
            e  = VEC[i];
            ek = e[17:14];
            step(e[31:28], e[27:18]);
            exp = {ek, (ek != 4'd0), e[13], e[12], e[11], e[10],
                   (ek == 4'd1), (ek == 4'd2 || ek == 4'd3)};
            obs = {kind, kind_valid, dq_oe, refresh_stb, wr_stb, test_mode, row_stb, col_stb};
            check(obs == exp, $sformatf("%s R12 vector %0d", tag_of(ek), i),
                  {21'd0, obs}, {21'd0, exp});
            if (ek == 4'd1 || ek == 4'd5 || ek == 4'd6 || ek == 4'd7)
                check(row_sel == e[9:0], $sformatf("%s row vector %0d", tag_of(ek), i),
                      {22'd0, row_sel}, {22'd0, e[9:0]});
        end

        // R3: latched column address
        step(4'b0111, 10'h011);
        step(4'b0011, 10'h3C5);
        check(col_stb && col_sel == 10'h3C5, "R3 column latch", {22'd0, col_sel}, 32'h3C5);
        step(4'b1111, 10'h000);

        // R10: hidden refresh keeps test mode, counter row 2 (R9)
        step(4'b0111, 10'h020);
        step(4'b0010, 10'h001);
        step(4'b1010, 10'h000);
        step(4'b0010, 10'h000);
        expect_ref(4'd7, 10'd2, "R9 hidden refresh row 2");
        check(test_mode && dq_oe, "R10 test mode kept by hidden refresh",
              {30'd0, test_mode, dq_oe}, 32'd3);
        step(4'b1010, 10'h000);
        step(4'b1111, 10'h000);
        check(test_mode, "R10 test mode kept by read cycle", {31'd0, test_mode}, 32'd1);
        // R11: stray CAS while RAS high
        step(4'b1001, 10'h000);
        check(!kind_valid && !col_stb && !wr_stb, "R11 stray CAS ignored",
              {29'd0, kind_valid, col_stb, wr_stb}, 32'd0);
        step(4'b1111, 10'h000);
        check(test_mode, "R10 test mode after stray CAS", {31'd0, test_mode}, 32'd1);
        // R10: row-only refresh clears
        step(4'b0111, 10'h0AA);
        step(4'b1111, 10'h000);
        expect_ref(4'd5, 10'h0AA, "R6 row-only refresh");
        check(!test_mode, "R10 cleared by row-only refresh", {31'd0, test_mode}, 32'd0);
        // R8 then R10 via counter refresh; counter unchanged by entry
        step(4'b1011, 10'h000);
        step(4'b1001, 10'h000);
        step(4'b0001, 10'h000);
        check(kind == 4'd8 && !refresh_stb && test_mode, "R8 test entry again",
              {27'd0, kind, refresh_stb}, 32'h10);
        step(4'b1011, 10'h000);
        step(4'b1111, 10'h000);
        step(4'b1011, 10'h000);
        step(4'b0011, 10'h000);
        expect_ref(4'd6, 10'd3, "R7 counter refresh row 3");
        check(!test_mode, "R10 cleared by counter refresh", {31'd0, test_mode}, 32'd0);
        step(4'b1011, 10'h000);
        step(4'b1111, 10'h000);

        // R7: walk the counter through the wrap
        for (int r = 4; r <= 1024; r++) begin
            step(4'b1011, 10'h000);
            step(4'b0011, 10'h000);
            expect_ref(4'd6, 10'(r), "R7 counter walk and wrap");
            step(4'b1011, 10'h000);
            step(4'b1111, 10'h000);
        end
        step(4'b1011, 10'h000);
        step(4'b0011, 10'h000);
        expect_ref(4'd6, 10'd1, "R7 after wrap");
        step(4'b1111, 10'h000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule